// File: doc/BRIEF.md
# Operand address resolver with pointer chasing and byte lanes

This block turns an effective address into the memory transactions needed to reach the operand on a 16-bit machine whose memory is organised in words. A request carries an address, a byte/word mode flag, a store flag and store data. In word mode the top address bit is an in-band indirection marker. When it is set, the lower bits name a memory word that holds a pointer. The block keeps fetching pointers as long as each fetched word has its top bit set.

In byte mode the full address is used. The upper bits select a word and the lowest bit selects one half of that word. Byte loads return the chosen half zero-extended. Byte stores are carried out as a read, a merge and a write back. A counter on the pointer chain ends runaway or looping chains with a fault instead of letting the block hang. Memory is reached through a single word-wide port with a request/ready handshake.

Top module: `operand_resolver`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, mem_req_o, done_o and fault_o are low.
- R2: A word-mode request whose address bit 15 is 0 issues exactly one read at word address addr_i[14:0]. The fetched word is returned on result_o.
- R3: A word-mode request whose address bit 15 is 1 first reads the pointer word at addr_i[14:0]. Any fetched word with bit 15 set is followed as a further pointer to the word at its bits 14:0. The first fetched word with bit 15 clear gives, in bits 14:0, the word address of the operand.
- R4: In byte mode, bits 15:1 form the word address and no indirection is done, even when bit 15 is set. Bit 0 = 0 selects data bits 15:8 and bit 0 = 1 selects bits 7:0. A byte load returns the selected byte zero-extended to 16 bits.
- R5: A byte store reads the addressed word and replaces only the selected byte with wdata_i[7:0]. It then writes the whole word back to the same word address. result_o returns the merged word.
- R6: A word-mode store writes wdata_i to the resolved operand address, after any indirection. result_o returns the written word.
- R7: Up to 16 pointer fetches are allowed per request. If the 16th fetched pointer word still has bit 15 set, fault_o pulses for one cycle, done_o stays low, and no further memory access is made for that request.
- R8: Once mem_req_o is raised, mem_req_o, mem_addr_o, mem_we_o and mem_wdata_o hold steady until a cycle in which mem_ready_i is high. A direct word read therefore keeps mem_req_o high for the memory's wait cycles plus two cycles.
- R9: done_o pulses for exactly one cycle per completed request, and never together with fault_o. result_o holds its value in the cycle after the pulse.
- R10: A request strobe that arrives while a request is in progress is ignored. It produces no completion and no change to the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Start strobe, accepted when idle |
| addr_i | input | 16 | Effective address (word or byte form) |
| byte_i | input | 1 | 1 = byte operand, 0 = word operand |
| we_i | input | 1 | 1 = store, 0 = load |
| wdata_i | input | 16 | Store data (byte stores use bits 7:0) |
| mem_req_o | output | 1 | Memory transaction request |
| mem_we_o | output | 1 | Memory write enable |
| mem_addr_o | output | 15 | Memory word address |
| mem_wdata_o | output | 16 | Memory write data |
| mem_rdata_i | input | 16 | Memory read data, valid with ready |
| mem_ready_i | input | 1 | Memory transaction complete |
| result_o | output | 16 | Final operand or written word |
| done_o | output | 1 | One-cycle completion pulse |
| fault_o | output | 1 | One-cycle indirection-limit fault pulse |

## Verification
Loads are run in several forms: direct, through one pointer, through two pointers, and through a chain of exactly sixteen pointers. The sixteen-pointer chain is the boundary case that must still complete. A seventeen-deep chain and a self-pointing loop must both fault. Byte loads on each lane show whether the lane mapping and zero extension are right. A byte load with bit 15 set shows that byte mode skips indirection. Byte stores on both lanes, each read back with a word load, show that the neighbouring byte survives. An indirect word store and its readback separate "written to the pointer" from "written to the target". Memory wait states and a strobe raised mid-request test the handshake hold and the busy-ignore behaviour.

// File: rtl/opres_pkg.sv
package opres_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_PTR,
      ST_READ,
      ST_WRITE,
      ST_DONE,
      ST_FAULT
   } opres_state_e;
endpackage

// File: rtl/opres_lane.sv
// Byte lane picker and merger for one data word.
module opres_lane #(
   parameter int DATA_W     = 16,
   parameter bit HI_ON_ZERO = 1'b1
) (
   input  logic [DATA_W-1:0]   word_i,
   input  logic                lane_i,
   input  logic [DATA_W/2-1:0] byte_i,
   output logic [DATA_W-1:0]   ext_o,
   output logic [DATA_W-1:0]   merged_o
);
   localparam int BW = DATA_W / 2;

   logic take_hi;

   generate
      if (HI_ON_ZERO) begin : g_hi_zero
         assign take_hi = ~lane_i;
      end else begin : g_hi_one
         assign take_hi = lane_i;
      end
   endgenerate

   always_comb begin
      if (take_hi) begin
         ext_o    = {{BW{1'b0}}, word_i[DATA_W-1:BW]};
         merged_o = {byte_i, word_i[BW-1:0]};
      end else begin
         ext_o    = {{BW{1'b0}}, word_i[BW-1:0]};
         merged_o = {word_i[DATA_W-1:BW], byte_i};
      end
   end
endmodule

// File: rtl/opres_hop_cnt.sv
// Counts pointer fetches of one request and flags the last allowed one.
module opres_hop_cnt #(
   parameter int MAX_HOPS = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear_i,
   input  logic step_i,
   output logic last_o
);
   localparam int CNT_W = $clog2(MAX_HOPS);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clear_i) begin
         cnt_q <= '0;
      end else if (step_i && !last_o) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign last_o = (cnt_q == CNT_W'(MAX_HOPS - 1));
endmodule

// File: rtl/operand_resolver.sv
module operand_resolver
   import opres_pkg::*;
#(
   parameter int DATA_W          = 16,
   parameter int MAX_HOPS        = 16,
   parameter bit HI_LANE_ON_ZERO = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_i,
   input  logic [DATA_W-1:0] addr_i,
   input  logic              byte_i,
   input  logic              we_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic              mem_req_o,
   output logic              mem_we_o,
   output logic [DATA_W-2:0] mem_addr_o,
   output logic [DATA_W-1:0] mem_wdata_o,
   input  logic [DATA_W-1:0] mem_rdata_i,
   input  logic              mem_ready_i,
   output logic [DATA_W-1:0] result_o,
   output logic              done_o,
   output logic              fault_o
);
   localparam int WA  = DATA_W - 1;
   localparam int MSB = DATA_W - 1;
   localparam int BW  = DATA_W / 2;

   generate
      if (DATA_W < 4 || (DATA_W % 2) != 0) begin : g_bad_width
         $error("operand_resolver: DATA_W must be even and at least 4");
      end
      if (MAX_HOPS < 2) begin : g_bad_hops
         $error("operand_resolver: MAX_HOPS must be at least 2");
      end
   endgenerate

   opres_state_e      state_q;
   logic [WA-1:0]     addr_q;
   logic              byte_q;
   logic              we_q;
   logic              lane_q;
   logic [DATA_W-1:0] wdata_q;
   logic [DATA_W-1:0] result_q;

   logic              start;
   logic              ptr_step;
   logic              hop_last;
   logic [DATA_W-1:0] byte_ext;
   logic [DATA_W-1:0] merged;

   assign start    = (state_q == ST_IDLE) && req_i;
   assign ptr_step = (state_q == ST_PTR) && mem_ready_i;

   opres_lane #(.DATA_W(DATA_W), .HI_ON_ZERO(HI_LANE_ON_ZERO)) u_lane (
      .word_i  (mem_rdata_i),
      .lane_i  (lane_q),
      .byte_i  (wdata_q[BW-1:0]),
      .ext_o   (byte_ext),
      .merged_o(merged)
   );

   opres_hop_cnt #(.MAX_HOPS(MAX_HOPS)) u_hops (
      .clk    (clk),
      .rst_n  (rst_n),
      .clear_i(start),
      .step_i (ptr_step),
      .last_o (hop_last)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         addr_q   <= '0;
         byte_q   <= 1'b0;
         we_q     <= 1'b0;
         lane_q   <= 1'b0;
         wdata_q  <= '0;
         result_q <= '0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (req_i) begin
                  byte_q  <= byte_i;
                  we_q    <= we_i;
                  wdata_q <= wdata_i;
                  if (byte_i) begin
                     addr_q  <= addr_i[DATA_W-1:1];
                     lane_q  <= addr_i[0];
                     state_q <= ST_READ;
                  end else begin
                     addr_q <= addr_i[WA-1:0];
                     lane_q <= 1'b0;
                     if (addr_i[MSB]) state_q <= ST_PTR;
                     else if (we_i)   state_q <= ST_WRITE;
                     else             state_q <= ST_READ;
                  end
               end
            end
            ST_PTR: begin
               if (mem_ready_i) begin
                  if (mem_rdata_i[MSB] && hop_last) begin
                     state_q <= ST_FAULT;
                  end else begin
                     addr_q <= mem_rdata_i[WA-1:0];
                     if (mem_rdata_i[MSB]) state_q <= ST_PTR;
                     else if (we_q)        state_q <= ST_WRITE;
                     else                  state_q <= ST_READ;
                  end
               end
            end
            ST_READ: begin
               if (mem_ready_i) begin
                  if (byte_q && we_q) begin
                     wdata_q <= merged;
                     state_q <= ST_WRITE;
                  end else begin
                     result_q <= byte_q ? byte_ext : mem_rdata_i;
                     state_q  <= ST_DONE;
                  end
               end
            end
            ST_WRITE: begin
               if (mem_ready_i) begin
                  result_q <= wdata_q;
                  state_q  <= ST_DONE;
               end
            end
            ST_DONE:  state_q <= ST_IDLE;
            ST_FAULT: state_q <= ST_IDLE;
            default:  state_q <= ST_IDLE;
         endcase
      end
   end

   assign mem_req_o   = (state_q == ST_PTR) || (state_q == ST_READ) ||
                        (state_q == ST_WRITE);
   assign mem_we_o    = (state_q == ST_WRITE);
   assign mem_addr_o  = addr_q;
   assign mem_wdata_o = wdata_q;
   assign result_o    = result_q;
   assign done_o      = (state_q == ST_DONE);
   assign fault_o     = (state_q == ST_FAULT);
endmodule

// File: rtl/opres_chk.sv
module opres_chk #(
   parameter int DATA_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              mem_req_o,
   input logic              mem_we_o,
   input logic [DATA_W-2:0] mem_addr_o,
   input logic [DATA_W-1:0] mem_wdata_o,
   input logic              mem_ready_i,
   input logic [DATA_W-1:0] result_o,
   input logic              done_o,
   input logic              fault_o
);
   always @(posedge clk) begin
      if (!rst_n) begin
         a_quiet_reset_r1: assert (!mem_req_o && !done_o && !fault_o)
            else $error("R1: outputs active during reset");
      end
   end

   p_hold_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_o && !mem_ready_i) |=>
         (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o) &&
          $stable(mem_wdata_o)))
      else $error("R8: request dropped or changed before ready");

   p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> (!done_o && $stable(result_o)))
      else $error("R9: done longer than one cycle or result moved");

   p_done_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(done_o && fault_o))
      else $error("R9: done and fault together");

   p_fault_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      fault_o |=> !fault_o)
      else $error("R7: fault longer than one cycle");

   p_fault_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      fault_o |-> !mem_req_o)
      else $error("R7: memory access during fault");
endmodule

bind operand_resolver opres_chk #(.DATA_W(DATA_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .mem_req_o  (mem_req_o),
   .mem_we_o   (mem_we_o),
   .mem_addr_o (mem_addr_o),
   .mem_wdata_o(mem_wdata_o),
   .mem_ready_i(mem_ready_i),
   .result_o   (result_o),
   .done_o     (done_o),
   .fault_o    (fault_o)
);

// File: tb/sim_operand_resolver.sv
`timescale 1ns/1ps
module sim_operand_resolver;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_i = 1'b0;
   logic [15:0] addr_i = '0;
   logic        byte_i = 1'b0;
   logic        we_i = 1'b0;
   logic [15:0] wdata_i = '0;
   logic        mem_req_o, mem_we_o;
   logic [14:0] mem_addr_o;
   logic [15:0] mem_wdata_o;
   logic [15:0] mem_rdata_i = '0;
   logic        mem_ready_i = 1'b0;
   logic [15:0] result_o;
   logic        done_o, fault_o;

   always #2.5 clk = ~clk;

   operand_resolver u0 (
      .clk(clk), .rst_n(rst_n), .req_i(req_i), .addr_i(addr_i),
      .byte_i(byte_i), .we_i(we_i), .wdata_i(wdata_i),
      .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
      .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i),
      .mem_ready_i(mem_ready_i), .result_o(result_o), .done_o(done_o),
      .fault_o(fault_o)
   );

   // memory model: ready after 'lat' wait cycles, one-cycle ready pulse
   logic [15:0] mem [0:255];
   int lat = 0;
   int wcnt = 0;
   always @(posedge clk) begin
      if (mem_ready_i) begin
         mem_ready_i <= 1'b0;
         if (mem_we_o) mem[mem_addr_o[7:0]] <= mem_wdata_o;
      end else if (mem_req_o) begin
         if (wcnt >= lat) begin
            mem_ready_i <= 1'b1;
            mem_rdata_i <= mem[mem_addr_o[7:0]];
            wcnt <= 0;
         end else begin
            wcnt <= wcnt + 1;
         end
      end
   end

   typedef struct {
      string       tag;
      logic [15:0] res;
      logic        flt;
   } exp_t;

   exp_t exp_q[$];
   int checks = 0;
   int errors = 0;
   int n_push = 0;
   int n_comp = 0;

   task automatic check(input bit ok, input string tag, input logic [15:0] act,
                        input logic [15:0] expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, expv);
      end
   endtask

   // monitor: pop expected item on each completion, then look one cycle on
   logic        post_pending = 1'b0;
   logic [15:0] post_res = '0;
   always @(negedge clk) begin
      if (post_pending) begin
         post_pending <= 1'b0;
         check(!done_o && !fault_o, "R9 single-cycle pulse",
               {14'd0, done_o, fault_o}, 16'h0000);
         check(result_o == post_res, "R9 result held", result_o, post_res);
      end
      if (rst_n && (done_o || fault_o)) begin
         n_comp++;
         if (exp_q.size() == 0) begin
            check(1'b0, "R10 unexpected completion", {15'd0, done_o}, 16'h0000);
         end else begin
            exp_t e;
            e = exp_q.pop_front();
            if (e.flt) begin
               check(fault_o && !done_o, e.tag, {14'd0, done_o, fault_o}, 16'h0001);
            end else begin
               check(done_o && !fault_o, e.tag, {14'd0, done_o, fault_o}, 16'h0002);
               check(result_o == e.res, e.tag, result_o, e.res);
               post_res     <= result_o;
               post_pending <= 1'b1;
            end
         end
      end
   end

   task automatic do_op(input logic [15:0] a, input logic b, input logic w,
                        input logic [15:0] d, input logic [15:0] expv,
                        input logic expf, input string tag, output int reqc);
      exp_t e;
      e.tag = tag; e.res = expv; e.flt = expf;
      exp_q.push_back(e);
      n_push++;
      @(negedge clk);
      req_i = 1'b1; addr_i = a; byte_i = b; we_i = w; wdata_i = d;
      @(negedge clk);
      req_i = 1'b0;
      reqc = mem_req_o ? 1 : 0;
      while (!(done_o || fault_o)) begin
         @(negedge clk);
         if (mem_req_o) reqc++;
      end
      @(negedge clk);
   endtask

   initial begin
      #(200000 * 5);
      errors++;
      checks++;
      $display("FAIL R9 watchdog: actual hung, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      int rc;
      for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
      mem[8'h20] = 16'h1234;
      mem[8'h30] = 16'h0021;
      mem[8'h21] = 16'hBEEF;
      mem[8'h31] = 16'h8030;
      mem[8'h50] = 16'hA1B2;
      mem[8'h0A] = 16'h800A;
      for (int i = 0; i < 15; i++) mem[100 + i] = 16'h8000 | 16'(101 + i);
      mem[115] = 16'h0040;
      mem[99]  = 16'h8064;
      mem[64]  = 16'h5A5A;

      // R1: quiet outputs in reset and right after
      repeat (3) @(negedge clk);
      check(!mem_req_o && !done_o && !fault_o, "R1 in reset",
            {13'd0, mem_req_o, done_o, fault_o}, 16'h0000);
      rst_n = 1'b1;
      @(negedge clk);
      check(!mem_req_o && !done_o && !fault_o, "R1 after reset",
            {13'd0, mem_req_o, done_o, fault_o}, 16'h0000);

      do_op(16'h0020, 1'b0, 1'b0, 16'h0, 16'h1234, 1'b0, "R2 direct read", rc);
      do_op(16'h8030, 1'b0, 1'b0, 16'h0, 16'hBEEF, 1'b0, "R3 one pointer", rc);
      do_op(16'h8031, 1'b0, 1'b0, 16'h0, 16'hBEEF, 1'b0, "R3 two pointers", rc);
      do_op(16'h8064, 1'b0, 1'b0, 16'h0, 16'h5A5A, 1'b0, "R7 sixteen hops ok", rc);
      do_op(16'h8063, 1'b0, 1'b0, 16'h0, 16'h0000, 1'b1, "R7 seventeen hops fault", rc);
      do_op(16'h800A, 1'b0, 1'b0, 16'h0, 16'h0000, 1'b1, "R7 pointer loop fault", rc);

      // R4: byte lanes, zero extension, no indirection in byte mode
      do_op(16'h00A0, 1'b1, 1'b0, 16'h0, 16'h00A1, 1'b0, "R4 byte hi lane", rc);
      do_op(16'h00A1, 1'b1, 1'b0, 16'h0, 16'h00B2, 1'b0, "R4 byte lo lane", rc);
      do_op(16'h80A0, 1'b1, 1'b0, 16'h0, 16'h00A1, 1'b0, "R4 byte bit15 not indirect", rc);

      // R5: byte stores keep the other byte
      do_op(16'h00A1, 1'b1, 1'b1, 16'hFFCC, 16'hA1CC, 1'b0, "R5 byte store lo", rc);
      do_op(16'h0050, 1'b0, 1'b0, 16'h0, 16'hA1CC, 1'b0, "R5 readback lo", rc);
      do_op(16'h00A0, 1'b1, 1'b1, 16'h3377, 16'h77CC, 1'b0, "R5 byte store hi", rc);
      do_op(16'h0050, 1'b0, 1'b0, 16'h0, 16'h77CC, 1'b0, "R5 readback hi", rc);

      // R6: indirect word store lands on target, pointer untouched
      do_op(16'h8030, 1'b0, 1'b1, 16'h1357, 16'h1357, 1'b0, "R6 indirect store", rc);
      do_op(16'h0021, 1'b0, 1'b0, 16'h0, 16'h1357, 1'b0, "R6 target readback", rc);
      do_op(16'h0030, 1'b0, 1'b0, 16'h0, 16'h0021, 1'b0, "R6 pointer intact", rc);

      // R8: wait states, request held for lat + 2 sampled cycles
      lat = 3;
      do_op(16'h0020, 1'b0, 1'b0, 16'h0, 16'h1234, 1'b0, "R8 read with waits", rc);
      check(rc == 5, "R8 request held through waits", 16'(rc), 16'd5);

      // R10: strobe during a request is ignored
      begin
         exp_t e;
         e.tag = "R10 busy strobe ignored"; e.res = 16'h1234; e.flt = 1'b0;
         exp_q.push_back(e);
         n_push++;
         @(negedge clk);
         req_i = 1'b1; addr_i = 16'h0020; byte_i = 1'b0; we_i = 1'b0;
         @(negedge clk);
         req_i = 1'b0;
         @(negedge clk);
         req_i = 1'b1; addr_i = 16'h0021;
         @(negedge clk);
         req_i = 1'b0;
         while (!(done_o || fault_o)) @(negedge clk);
         repeat (12) @(negedge clk);
      end
      check(n_comp == n_push, "R10 completion count", 16'(n_comp), 16'(n_push));
      check(exp_q.size() == 0, "R10 scoreboard drained", 16'(exp_q.size()), 16'd0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule